// File: doc/BRIEF.md
# Streaming IQ Demodulator and State Discriminator

This block sits behind the sampler of a shared readout line. Several qubits share that line, and each one answers at its own tone. For every channel, the block keeps a phase accumulator that steps by that channel's frequency word on each accepted sample. A sine/cosine table turns the phase into a cosine and a sine value. Each sample is multiplied by both values, and the products are summed over a capture window, so the I and Q sums are complete as soon as the last sample has been taken.

When the window closes, each channel rotates its (I, Q) point with a pair of signed fixed-point coefficients. These are chosen so that the line between the two state clusters becomes horizontal. The rotated I value is then compared with a per-channel threshold. A single done pulse delivers one decision bit per channel, together with the raw sums. A whole shot of samples therefore collapses into a few bits. The coefficients and thresholds are plain inputs, held steady by the surrounding logic between shots.

Top module: `iq_state_discriminator`

## Requirements
- R1: After reset, `done` is low and every state bit, I sum and Q sum is zero.
- R2: A `start` pulse while the block is idle opens a window. It clears every channel's sums and phase, and it latches `win_len` as the number of samples in the window; a length of zero counts as one.
- R3: Only cycles with `smp_valid` high inside an open window are taken. Each taken sample advances a channel's 16-bit phase by its frequency word, wrapping modulo 2^16. The first sample uses phase 0.
- R4: The table is indexed by the top 8 phase bits and has an amplitude of 2047. Index 0 gives cos 2047 and sin 0. Index 64 gives cos 0 and sin 2047. Index 128 gives cos -2047 and sin 0. Index 192 gives cos 0 and sin -2047.
- R5: The I sum is the full-precision sum of sample times cosine, and the Q sum is the sum of sample times sine. Both are signed 34-bit values.
- R6: `done` is a single-cycle pulse, high in the fourth cycle after the clock edge that takes the window's last sample.
- R7: A `start` while a window is open, or before its result has been delivered, is ignored, and so is a change of `win_len`.
- R8: The rotated value is floor((I*c + Q*s) / 2^14), with c and s signed 16-bit coefficients. A channel's state bit is 1 only when the rotated value is strictly greater than its signed 34-bit threshold.
- R9: Each channel uses its own frequency word, coefficients and threshold.
- R10: The state bits and sums hold their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a capture window when idle |
| win_len | input | 10 | Window length in samples, latched at start |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | 12 | Signed sample |
| freq_words | input | 64 | Per-channel phase step, 16 bits each, channel 0 lowest |
| rot_cos | input | 64 | Per-channel signed rotation cosine, 2.14 fixed point |
| rot_sin | input | 64 | Per-channel signed rotation sine, 2.14 fixed point |
| thresholds | input | 136 | Per-channel signed decision threshold, 34 bits each |
| done | output | 1 | Result pulse |
| state_bits | output | 4 | Decision bit per channel |
| i_sums | output | 136 | Per-channel signed I sum |
| q_sums | output | 136 | Per-channel signed Q sum |

## Verification
The assertions check on every cycle the properties that follow from state:
- the phase holds when no sample is taken;
- the sums are zero right after a window opens;
- the sample count stays below the latched length;
- the last sample leads into the drain state;
- `done` never lasts two cycles;
- the decision bits never move between results.

The remaining behaviours only show in the bench's scenarios: the arithmetic of the sums and the rotation against a model, the exact latency, gaps in the sample stream, an ignored restart, the zero-length window, and the strict threshold boundary.

// File: rtl/iqd_pkg.sv
package iqd_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE    = 2'd0,
    WIN_CAPTURE = 2'd1,
    WIN_DRAIN   = 2'd2
  } win_state_e;
endpackage

// File: rtl/iqd_sine_rom.sv
// Full-wave sine table with two registered read ports (sine and cosine).
module iqd_sine_rom #(
  parameter int LUT_AW = 8,
  parameter int LUT_W  = 12
) (
  input  logic                    clk,
  input  logic [LUT_AW-1:0]       addr,
  output logic signed [LUT_W-1:0] sin_q,
  output logic signed [LUT_W-1:0] cos_q
);
  localparam int DEPTH = 1 << LUT_AW;
  localparam int HALF  = DEPTH / 2;
  localparam int QTR   = DEPTH / 4;
  localparam int AMP   = (1 << (LUT_W - 1)) - 1;

  // Rational half-wave approximation, exact at 0 and at the peak.
  function automatic logic signed [LUT_W-1:0] wave(input int k);
    longint t, u, v;
    t = (k < HALF) ? longint'(k) : longint'(k - HALF);
    u = t * (longint'(HALF) - t);
    v = (longint'(AMP) * 16 * u) / (5 * longint'(HALF) * longint'(HALF) - 4 * u);
    if (k >= HALF) v = -v;
    return LUT_W'(v);
  endfunction

  logic signed [LUT_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
    assign tbl[g] = wave(g);
  end

  logic [LUT_AW-1:0] cos_addr;
  assign cos_addr = addr + LUT_AW'(QTR);

  always_ff @(posedge clk) begin
    sin_q <= tbl[addr];
    cos_q <= tbl[cos_addr];
  end
endmodule

// File: rtl/iqd_window_ctl.sv
// Capture window sequencing shared by all channels.
module iqd_window_ctl
  import iqd_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] win_len,
  input  logic             smp_valid,
  input  logic             res_done,
  output logic             clr,
  output logic             go,
  output logic             last
);
  win_state_e       st;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] lim;

  assign clr  = (st == WIN_IDLE) && start;
  assign go   = (st == WIN_CAPTURE) && smp_valid;
  assign last = go && (cnt == lim - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= WIN_IDLE;
      cnt <= '0;
      lim <= '0;
    end else begin
      case (st)
        WIN_IDLE: if (start) begin
          st  <= WIN_CAPTURE;
          cnt <= '0;
          lim <= (win_len == '0) ? LEN_W'(1) : win_len;
        end
        WIN_CAPTURE: if (go) begin
          cnt <= cnt + LEN_W'(1);
          if (last) st <= WIN_DRAIN;
        end
        WIN_DRAIN: if (res_done) st <= WIN_IDLE;
        default: st <= WIN_IDLE;
      endcase
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (st == WIN_CAPTURE) |-> (cnt < lim)); // R2
  AST_CLR_OPENS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (st == WIN_CAPTURE)); // R2
  AST_LAST_DRAIN: assert property (@(posedge clk) disable iff (rst)
    last |=> (st == WIN_DRAIN)); // R6
endmodule

// File: rtl/iqd_channel.sv
// One qubit channel: NCO, mixer, accumulators, rotation and decision.
module iqd_channel #(
  parameter int SMP_W  = 12,
  parameter int PH_W   = 16,
  parameter int LUT_AW = 8,
  parameter int LUT_W  = 12,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 34
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     go,
  input  logic                     last,
  input  logic signed [SMP_W-1:0]  smp,
  input  logic [PH_W-1:0]          fw,
  input  logic signed [COEF_W-1:0] rc,
  input  logic signed [COEF_W-1:0] rs,
  input  logic signed [ACC_W-1:0]  th,
  output logic                     res_vld,
  output logic                     st_bit,
  output logic signed [ACC_W-1:0]  i_out,
  output logic signed [ACC_W-1:0]  q_out
);
  localparam int PROD_W = SMP_W + LUT_W;
  localparam int EXT_W  = ACC_W - PROD_W;
  localparam int FRAC   = COEF_W - 2;
  localparam int MUL_W  = ACC_W + COEF_W + 1;
  localparam int ROT_W  = MUL_W - FRAC;

  // Phase generation
  logic [PH_W-1:0] phase;
  always_ff @(posedge clk) begin
    if (rst || clr) phase <= '0;
    else if (go)    phase <= phase + fw;
  end

  // Stage 1: table read and sample alignment
  logic signed [LUT_W-1:0] s1_sin, s1_cos;
  logic signed [SMP_W-1:0] s1_smp;
  logic                    s1_vld, s1_last;

  iqd_sine_rom #(.LUT_AW(LUT_AW), .LUT_W(LUT_W)) rom_i (
    .clk  (clk),
    .addr (phase[PH_W-1 -: LUT_AW]),
    .sin_q(s1_sin),
    .cos_q(s1_cos)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_last <= 1'b0;
      s1_smp  <= '0;
    end else begin
      s1_vld  <= go;
      s1_last <= last;
      s1_smp  <= smp;
    end
  end

  // Stage 2: mixing products
  logic signed [PROD_W-1:0] p_i, p_q;
  logic                     s2_vld, s2_last;
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld  <= 1'b0;
      s2_last <= 1'b0;
      p_i     <= '0;
      p_q     <= '0;
    end else begin
      s2_vld  <= s1_vld;
      s2_last <= s1_last;
      p_i     <= PROD_W'(s1_smp) * PROD_W'(s1_cos);
      p_q     <= PROD_W'(s1_smp) * PROD_W'(s1_sin);
    end
  end

  // Stage 3: accumulation
  logic signed [ACC_W-1:0] acc_i, acc_q;
  logic                    s3_last;
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_i <= '0;
      acc_q <= '0;
    end else if (s2_vld) begin
      acc_i <= acc_i + {{EXT_W{p_i[PROD_W-1]}}, p_i};
      acc_q <= acc_q + {{EXT_W{p_q[PROD_W-1]}}, p_q};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) s3_last <= 1'b0;
    else     s3_last <= s2_vld && s2_last;
  end

  // Stage 4: rotation
  logic signed [MUL_W-1:0] rot_full;
  logic signed [ROT_W-1:0] rot;
  logic                    s4_vld;
  always_comb begin
    rot_full = MUL_W'(acc_i) * MUL_W'(rc) + MUL_W'(acc_q) * MUL_W'(rs);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s4_vld <= 1'b0;
      rot    <= '0;
    end else begin
      s4_vld <= s3_last;
      if (s3_last) rot <= ROT_W'(rot_full >>> FRAC);
    end
  end

  // Stage 5: decision and result registers
  logic signed [ROT_W-1:0] th_ext;
  assign th_ext = ROT_W'(th);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      st_bit  <= 1'b0;
      i_out   <= '0;
      q_out   <= '0;
    end else begin
      res_vld <= s4_vld;
      if (s4_vld) begin
        st_bit <= (rot > th_ext);
        i_out  <= acc_i;
        q_out  <= acc_q;
      end
    end
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!go && !clr) |=> $stable(phase)); // R3
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_i == '0 && acc_q == '0)); // R2
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !s4_vld |=> ($stable(st_bit) && $stable(i_out) && $stable(q_out))); // R10
endmodule

// File: rtl/iq_state_discriminator.sv
module iq_state_discriminator #(
  parameter int N_CH   = 4,
  parameter int SMP_W  = 12,
  parameter int PH_W   = 16,
  parameter int LUT_AW = 8,
  parameter int LUT_W  = 12,
  parameter int LEN_W  = 10,
  parameter int COEF_W = 16,
  parameter int ACC_W  = SMP_W + LUT_W + LEN_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [LEN_W-1:0]         win_len,
  input  logic                     smp_valid,
  input  logic signed [SMP_W-1:0]  smp_data,
  input  logic [N_CH*PH_W-1:0]     freq_words,
  input  logic [N_CH*COEF_W-1:0]   rot_cos,
  input  logic [N_CH*COEF_W-1:0]   rot_sin,
  input  logic [N_CH*ACC_W-1:0]    thresholds,
  output logic                     done,
  output logic [N_CH-1:0]          state_bits,
  output logic [N_CH*ACC_W-1:0]    i_sums,
  output logic [N_CH*ACC_W-1:0]    q_sums
);
  logic            clr, go, last;
  logic [N_CH-1:0] ch_vld;

  assign done = &ch_vld;

  iqd_window_ctl #(.LEN_W(LEN_W)) ctl_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .win_len  (win_len),
    .smp_valid(smp_valid),
    .res_done (done),
    .clr      (clr),
    .go       (go),
    .last     (last)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    iqd_channel #(
      .SMP_W(SMP_W), .PH_W(PH_W), .LUT_AW(LUT_AW),
      .LUT_W(LUT_W), .COEF_W(COEF_W), .ACC_W(ACC_W)
    ) ch_i (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr),
      .go     (go),
      .last   (last),
      .smp    (smp_data),
      .fw     (freq_words[c*PH_W +: PH_W]),
      .rc     (rot_cos[c*COEF_W +: COEF_W]),
      .rs     (rot_sin[c*COEF_W +: COEF_W]),
      .th     (thresholds[c*ACC_W +: ACC_W]),
      .res_vld(ch_vld[c]),
      .st_bit (state_bits[c]),
      .i_out  (i_sums[c*ACC_W +: ACC_W]),
      .q_out  (q_sums[c*ACC_W +: ACC_W])
    );
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
endmodule

// File: tb/iq_state_discriminator_tb_top.sv
module iq_state_discriminator_tb_top;
  localparam int N  = 4;
  localparam int LW = 10;
  localparam int AW = 34;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [LW-1:0] win_len = '0;
  logic          smp_valid = 1'b0;
  logic signed [11:0] smp_data = '0;
  logic [N*16-1:0] freq_words;
  logic [N*16-1:0] rot_cos = '0;
  logic [N*16-1:0] rot_sin = '0;
  logic [N*AW-1:0] thresholds = '0;
  logic            done;
  logic [N-1:0]    state_bits;
  logic [N*AW-1:0] i_sums, q_sums;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  iq_state_discriminator dut_i (
    .clk(clk), .rst(rst), .start(start), .win_len(win_len),
    .smp_valid(smp_valid), .smp_data(smp_data), .freq_words(freq_words),
    .rot_cos(rot_cos), .rot_sin(rot_sin), .thresholds(thresholds),
    .done(done), .state_bits(state_bits), .i_sums(i_sums), .q_sums(q_sums)
  );

  // Frequency words: zero, quarter, half and three-quarter turn per sample.
  localparam logic [15:0] FW [N] = '{16'h0000, 16'h4000, 16'h8000, 16'hC000};

  typedef struct packed {
    int len; int a; int b; int rc; int rs; int th;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{8,   100,   100, 16384,      0,       0},
    '{6,   500,  -300,     0,  16384,   -1000},
    '{12, -2048, 2047, 11585,  11585,    5000},
    '{5,     1,    -1, -16384,  8192,       0},
    '{16, 1000,     0, 16384, -16384, -100000}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  function automatic longint get_i(input int c);
    return longint'($signed(i_sums[c*AW +: AW]));
  endfunction
  function automatic longint get_q(input int c);
    return longint'($signed(q_sums[c*AW +: AW]));
  endfunction

  // Independent model of the requirements (R3, R4, R5, R8).
  function automatic void model(input int c, input int lim, input int a, input int b,
                                input int rc, input int rs,
                                output longint ei, output longint eq, output longint er);
    ei = 0; eq = 0;
    for (int k = 0; k < lim; k++) begin
      longint ph, s, co, si;
      ph = (longint'(k) * longint'(FW[c])) % 65536;
      s  = (k % 2 == 1) ? longint'(b) : longint'(a);
      case (ph >> 8)
        0:       begin co = 2047;  si = 0;     end
        64:      begin co = 0;     si = 2047;  end
        128:     begin co = -2047; si = 0;     end
        192:     begin co = 0;     si = -2047; end
        default: begin co = 0;     si = 0;     end
      endcase
      ei += s * co;
      eq += s * si;
    end
    er = (ei * longint'(rc) + eq * longint'(rs)) >>> 14;
  endfunction

  task automatic set_cfg(input int rc, input int rs, input longint th);
    for (int c = 0; c < N; c++) begin
      rot_cos[c*16 +: 16]    = 16'(rc);
      rot_sin[c*16 +: 16]    = 16'(rs);
      thresholds[c*AW +: AW] = AW'(th);
    end
  endtask

  // Drive one window; returns at the negedge after the last taken sample.
  task automatic drive(input int len, input int a, input int b, input bit gaps, input bit mid);
    int lim;
    lim = (len == 0) ? 1 : len;
    @(negedge clk);
    start = 1'b1; win_len = LW'(len);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < lim; k++) begin
      if (gaps && (k % 3 == 1)) begin
        smp_valid = 1'b0; smp_data = 12'sh5A5;
        @(negedge clk);
      end
      smp_valid = 1'b1;
      smp_data  = 12'((k % 2 == 1) ? b : a);
      if (mid && k == 1) begin start = 1'b1; win_len = LW'(3); end
      @(negedge clk);
      smp_valid = 1'b0; start = 1'b0;
    end
  endtask

  task automatic wait_done(input string tag);
    int lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 4, {tag, " R6 latency"}, lat, 4);
  endtask

  task automatic check_all(input string tag, input int lim, input int a, input int b,
                           input int rc, input int rs, input longint th);
    for (int c = 0; c < N; c++) begin
      longint ei, eq, er;
      model(c, lim, a, b, rc, rs, ei, eq, er);
      chk(get_i(c) == ei, {tag, " R5 I sum"}, get_i(c), ei);
      chk(get_q(c) == eq, {tag, " R5 Q sum"}, get_q(c), eq);
      chk(state_bits[c] == (er > th), {tag, " R8 state bit"}, longint'(state_bits[c]), longint'(er > th));
    end
  endtask

  task automatic run(input string tag, input int len, input int a, input int b, input int rc,
                     input int rs, input longint th, input bit gaps, input bit mid);
    set_cfg(rc, rs, th);
    drive(len, a, b, gaps, mid);
    wait_done(tag);
    check_all(tag, (len == 0) ? 1 : len, a, b, rc, rs, th);
    repeat (3) @(negedge clk);
    chk(done == 1'b0, {tag, " R6 done single pulse"}, longint'(done), 0);
    check_all({tag, " R10 hold"}, (len == 0) ? 1 : len, a, b, rc, rs, th);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    for (int c = 0; c < N; c++) freq_words[c*16 +: 16] = FW[c];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(done == 1'b0, "R1 done", longint'(done), 0);
    chk(state_bits == '0, "R1 state bits", longint'(state_bits), 0);
    chk(i_sums == '0 && q_sums == '0, "R1 sums", 1, 0);

    // Vector table: R3 R4 R5 R8 R9, each window also shows R2 clearing.
    for (int v = 0; v < 5; v++) begin
      run($sformatf("vec%0d", v), VECS[v].len, VECS[v].a, VECS[v].b,
          VECS[v].rc, VECS[v].rs, longint'(VECS[v].th), 1'b0, 1'b0);
    end

    // R3: invalid cycles inside the window are not taken.
    run("gaps R3", 12, -2048, 2047, 11585, 11585, 5000, 1'b1, 1'b0);
    // R7: restart and length change during capture ignored.
    run("restart R7", 9, 300, -700, 16384, 8192, 0, 1'b0, 1'b1);
    // R2: zero length counts as one sample.
    run("zero len R2", 0, 777, 0, 16384, 0, 0, 1'b0, 1'b0);
    // R5: full-length window at full negative scale.
    run("max len R5", 1023, -2048, -2048, 16384, 0, 0, 1'b0, 1'b0);

    // R8 R9: strict comparison at each channel's own threshold.
    begin
      longint er_c [N];
      for (int c = 0; c < N; c++) begin
        longint ei, eq;
        model(c, 4, 100, -50, 16384, 4096, ei, eq, er_c[c]);
      end
      set_cfg(16384, 4096, 0);
      for (int c = 0; c < N; c++) thresholds[c*AW +: AW] = AW'(er_c[c]);
      drive(4, 100, -50, 1'b0, 1'b0);
      wait_done("equal");
      chk(state_bits == '0, "R8 R9 equal threshold gives zero", longint'(state_bits), 0);
      repeat (3) @(negedge clk);
      for (int c = 0; c < N; c++) thresholds[c*AW +: AW] = AW'(er_c[c] - 1);
      drive(4, 100, -50, 1'b0, 1'b0);
      wait_done("below");
      chk(state_bits == '1, "R8 R9 threshold one below gives one", longint'(state_bits), 15);
    end

    report();
  end
endmodule